// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It supports six operations: register add and subtract (both wrap modulo 2^32), OR with a zero-extended immediate, word load, word store and branch-if-equal. The core holds a program counter and a 32 x 32-bit register file. It also holds two small word-addressed memories, one for instructions and one for data. Within a single cycle the core fetches the word at the program counter, reads two source registers, runs the ALU and accesses data memory. On the next rising edge it writes the register file, the data memory and the program counter together.

A load port fills both memories and reads data memory back. The surrounding logic loads the memories while reset is held, then releases reset so the core starts at address 0. Every data-memory write the core makes also appears on a store-observation bus.

Top module: `single_cycle_core`

## Requirements
- R1: While `rst` is high, the core writes neither the registers nor the data memory, and `dbus_we` is 0. At the first rising edge where `rst` is high, `pc_o` becomes 0 and all registers become 0.
- R2: For opcode 0x00, funct 0x21 writes R[rs]+R[rt] into R[rd] and funct 0x23 writes R[rs]-R[rt] into R[rd], both modulo 2^32. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 0x0D writes R[rs] OR {16'h0, imm[15:0]} into R[rt].
- R4: Opcode 0x23 loads R[rt] from the data-memory word at R[rs]+sign-extended imm[15:0].
- R5: Opcode 0x2B writes R[rt] to the data-memory word at R[rs]+sign-extended imm. In the same cycle it shows `dbus_we`=1, the byte address on `dbus_addr` and R[rt] on `dbus_wdata`. No other instruction raises `dbus_we`.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm<<2) when R[rs]==R[rt], and to PC+4 otherwise. All other instructions go to PC+4.
- R7: Register 0 always reads as 0. Writes to register 0 are dropped.
- R8: Any other opcode, or opcode 0x00 with any other funct, changes no register and no memory and advances PC by 4.
- R9: Memories are indexed by byte-address bits [k+1:2], where k is log2 of their depth, and higher address bits are ignored. With the default depths, data address 0x108 selects data word 2.
- R10: When `ld_en` is 1, `ld_wdata` is written at the next edge to word `ld_addr`. The target is the data memory if `ld_dmem` is 1, otherwise the instruction memory. `ld_rdata` always shows data word `ld_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | 7 | Load-port word index |
| ld_wdata | input | 32 | Load-port write word |
| ld_rdata | output | 32 | Data-memory word at `ld_addr` |
| pc_o | output | 32 | Current program counter |
| dbus_we | output | 1 | Core store in this cycle |
| dbus_addr | output | 32 | Byte address of the core's data access |
| dbus_wdata | output | 32 | Word being stored |

## Verification
The hardest case to reach from the ports is a taken branch to a random forward target whose operands came from earlier random arithmetic. Most random register pairs differ, so the branch rarely fires. The stimulus draws register numbers for branches from a small pool so equality happens often, and it limits forward offsets so every random program falls into a fixed epilogue. That epilogue stores every register to memory. Register state is never visible directly, so the bench reads it back through the stores, and it compares every cycle's program counter and store bus against a bench model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    ext_signed;
    alu_op_e alu_op;
    logic    wb_from_mem;
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    logic    illegal;
  } ctrl_t;

  function automatic logic [XLEN-1:0] alu_calc(alu_op_e op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] extend_imm(logic [15:0] imm, logic signed_ext);
    return signed_ext ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_is_rd = 1'b1;
          ctrl.reg_wr    = 1'b1;
          ctrl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end else begin
          ctrl.illegal = 1'b1;
        end
      end
      OPC_ORI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = ALU_OR;
        ctrl.reg_wr   = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.ext_signed  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
      end
      OPC_STOR: begin
        ctrl.b_is_imm   = 1'b1;
        ctrl.ext_signed = 1'b1;
        ctrl.mem_wr     = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.ext_signed = 1'b1;
        ctrl.alu_op     = ALU_SUB;
        ctrl.branch     = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] offset,
  output logic [W-1:0] pc_q
);
  logic [W-1:0] seq_pc;
  logic [W-1:0] br_target;

  assign seq_pc    = pc_q + W'(4);
  assign br_target = seq_pc + (offset << 2);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= take ? br_target : seq_pc;
  end

  p_seq_pc_r6: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_q == $past(pc_q) + W'(4));
  p_branch_pc_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == $past(pc_q) + W'(4) + ($past(offset) << 2));
endmodule

// File: rtl/single_cycle_core.sv
module single_cycle_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 128,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS),
  localparam int RA = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic            ld_dmem,
  input  logic [IA-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_wdata,
  output logic [XLEN-1:0] ld_rdata,
  output logic [XLEN-1:0] pc_o,
  output logic            dbus_we,
  output logic [XLEN-1:0] dbus_addr,
  output logic [XLEN-1:0] dbus_wdata
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, instr, bus_a, bus_b, imm_x, alu_b, alu_y, mem_rd, wb_data;
  logic [RA-1:0]   f_rs, f_rt, f_rd, wr_sel;
  ctrl_t           ctrl;
  logic            operands_equal, take_branch, reg_we, mem_we;

  assign instr = imem[pc[IA+1:2]];
  assign f_rs  = instr[21+RA-1:21];
  assign f_rt  = instr[16+RA-1:16];
  assign f_rd  = instr[11+RA-1:11];

  sc_decode u_decode (.opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  assign wr_sel = ctrl.dst_is_rd ? f_rd : f_rt;
  assign reg_we = ctrl.reg_wr & ~rst;
  assign mem_we = ctrl.mem_wr & ~rst;

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wa(wr_sel), .wd(wb_data),
    .ra(f_rs), .rb(f_rt), .qa(bus_a), .qb(bus_b)
  );

  assign imm_x          = extend_imm(instr[15:0], ctrl.ext_signed);
  assign alu_b          = ctrl.b_is_imm ? imm_x : bus_b;
  assign alu_y          = alu_calc(ctrl.alu_op, bus_a, alu_b);
  assign operands_equal = (alu_y == '0);
  assign take_branch    = ctrl.branch & operands_equal;

  assign mem_rd  = dmem[alu_y[DA+1:2]];
  assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;

  sc_next_pc #(.W(XLEN)) u_pc (
    .clk(clk), .rst(rst), .take(take_branch), .offset(imm_x), .pc_q(pc)
  );

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr] <= ld_wdata;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem) dmem[ld_addr[DA-1:0]] <= ld_wdata;
    else if (mem_we)      dmem[alu_y[DA+1:2]] <= bus_b;
  end

  assign ld_rdata   = dmem[ld_addr[DA-1:0]];
  assign pc_o       = pc;
  assign dbus_we    = mem_we;
  assign dbus_addr  = alu_y;
  assign dbus_wdata = bus_b;

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !dbus_we && !reg_we);
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |-> !reg_we && !mem_we && !take_branch);
  p_one_effect_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.branch, ctrl.illegal}));
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> bus_a == '0);
endmodule

// File: tb/test_single_cycle_core.sv
module test_single_cycle_core;
  localparam int IW = 128;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [31:0] ld_wdata = '0;
  logic [31:0] ld_rdata, pc_o, dbus_addr, dbus_wdata;
  logic        dbus_we;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_imem [IW];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  always #2 clk = ~clk;

  single_cycle_core i_single_cycle_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .pc_o(pc_o), .dbus_we(dbus_we),
    .dbus_addr(dbus_addr), .dbus_wdata(dbus_wdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic string pc_tag(logic [31:0] ins);
    if (ins[31:26] == 6'h04) return "R6 branch next pc";
    if (ins[31:26] == 6'h0D || ins[31:26] == 6'h23 || ins[31:26] == 6'h2B) return "R6 sequential pc";
    if (ins[31:26] == 6'h00 && (ins[5:0] == 6'h21 || ins[5:0] == 6'h23)) return "R6 sequential pc";
    return "R8 undefined advances pc";
  endfunction

  // Bench model of one instruction; also checks the store bus of this cycle.
  task automatic step_model();
    logic [31:0] ins, a, b, ea, nxt;
    logic [5:0]  op;
    int rs, rt, rd, dst;
    logic        wr, st;
    logic [31:0] val;
    ins = m_imem[m_pc[8:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = m_reg[rs]; b = m_reg[rt];
    ea = a + sext(ins[15:0]);
    nxt = m_pc + 4; wr = 1'b0; st = 1'b0; dst = 0; val = '0;
    case (op)
      6'h00: if (ins[5:0] == 6'h21) begin wr = 1; dst = rd; val = a + b; end
             else if (ins[5:0] == 6'h23) begin wr = 1; dst = rd; val = a - b; end
      6'h0D: begin wr = 1; dst = rt; val = a | {16'h0, ins[15:0]}; end
      6'h23: begin wr = 1; dst = rt; val = m_dmem[ea[7:2]]; end
      6'h2B: st = 1'b1;
      6'h04: if (a == b) nxt = m_pc + 4 + (sext(ins[15:0]) << 2);
      default: ;
    endcase
    check(pc_tag(ins), pc_o, m_pc);
    check("R5 store strobe", {31'd0, dbus_we}, {31'd0, st});
    if (st) begin
      check("R5 store address", dbus_addr, ea);
      check("R5 store data", dbus_wdata, b);
      m_dmem[ea[7:2]] = b;
    end
    if (wr && dst != 0) m_reg[dst] = val;
    m_pc = nxt;
  endtask

  task automatic load_and_run(int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < IW; i++) begin
      ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = 7'(i); ld_wdata = m_imem[i];
      @(negedge clk);
    end
    for (int i = 0; i < DW; i++) begin
      ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = 7'(i); ld_wdata = m_dmem[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    #1;
    check("R1 no store during reset", {31'd0, dbus_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    #1 check("R1 pc after reset", pc_o, 32'd0);
    for (int c = 0; c < cycles; c++) begin
      step_model();
      @(negedge clk);
      #1;
    end
    for (int w = 0; w < DW; w++) begin
      ld_addr = 7'(w);
      #1 check("R5 final data memory", ld_rdata, m_dmem[w]);
    end
  endtask

  function automatic logic [31:0] rand_instr(int idx);
    int k, lim;
    k = $urandom % 9;
    case (k)
      0: return enc_r(6'h21, $urandom % 32, $urandom % 32, $urandom % 32);
      1: return enc_r(6'h23, $urandom % 32, $urandom % 32, $urandom % 32);
      2, 3: return enc_i(6'h0D, $urandom % 32, $urandom % 32, 16'($urandom));
      4: return enc_i(6'h23, $urandom % 32, $urandom % 32, 16'($urandom));
      5: return enc_i(6'h2B, $urandom % 32, $urandom % 32, 16'($urandom));
      6, 7: begin
        lim = 63 - idx;
        return enc_i(6'h04, $urandom % 4, $urandom % 4, 16'(($urandom % 4) % (lim + 1)));
      end
      default: return ($urandom % 2) ? {6'h3F, 26'($urandom)} : enc_r(6'h20, $urandom % 32, $urandom % 32, $urandom % 32);
    endcase
  endfunction

  task automatic build_random();
    for (int i = 0; i < 64; i++) m_imem[i] = rand_instr(i);
    for (int k = 1; k < 32; k++) m_imem[63 + k] = enc_i(6'h2B, 0, k, 16'(4 * k));
    for (int i = 95; i < IW; i++) m_imem[i] = enc_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < DW; i++) m_dmem[i] = $urandom;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // Directed program
    for (int i = 0; i < IW; i++) m_imem[i] = enc_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < DW; i++) m_dmem[i] = 32'hA500_0000 | i;
    m_imem[0]  = enc_i(6'h0D, 0, 1, 16'hFFFF);
    m_imem[1]  = enc_i(6'h0D, 0, 0, 16'h1234);
    m_imem[2]  = enc_r(6'h21, 1, 1, 2);
    m_imem[3]  = enc_r(6'h23, 0, 1, 3);
    m_imem[4]  = enc_r(6'h21, 3, 3, 4);
    m_imem[5]  = enc_i(6'h0D, 0, 6, 16'h0008);
    m_imem[6]  = enc_i(6'h23, 6, 5, 16'hFFFC);
    m_imem[7]  = enc_i(6'h2B, 6, 5, 16'h0100);
    m_imem[8]  = enc_i(6'h2B, 0, 0, 16'h0000);
    m_imem[9]  = enc_i(6'h04, 1, 2, 16'h0005);
    m_imem[10] = enc_i(6'h04, 6, 6, 16'h0001);
    m_imem[11] = enc_i(6'h0D, 0, 7, 16'hDEAD);
    m_imem[12] = enc_i(6'h2B, 0, 7, 16'h000C);
    m_imem[13] = 32'hFC00_FFFF;
    m_imem[14] = enc_r(6'h20, 0, 0, 1);
    m_imem[15] = enc_i(6'h2B, 0, 1, 16'h0010);
    m_imem[16] = enc_i(6'h2B, 0, 3, 16'h0014);
    m_imem[17] = enc_i(6'h2B, 0, 4, 16'h0018);
    m_imem[18] = enc_i(6'h2B, 0, 2, 16'h001C);
    load_and_run(40);
    ld_addr = 7'd8;  #1 check("R10 load port readback", ld_rdata, 32'hA500_0008);
    ld_addr = 7'd0;  #1 check("R7 stored r0 is zero", ld_rdata, 32'h0);
    ld_addr = 7'd2;  #1 check("R9 R4 wrapped store of loaded word", ld_rdata, 32'hA500_0001);
    ld_addr = 7'd3;  #1 check("R6 skipped instruction left r7 zero", ld_rdata, 32'h0);
    ld_addr = 7'd4;  #1 check("R3 R8 ori value kept past undefined ops", ld_rdata, 32'h0000_FFFF);
    ld_addr = 7'd5;  #1 check("R2 subtract wraps", ld_rdata, 32'hFFFF_0001);
    ld_addr = 7'd6;  #1 check("R2 add wraps", ld_rdata, 32'hFFFE_0002);
    ld_addr = 7'd7;  #1 check("R2 add", ld_rdata, 32'h0001_FFFE);
    check("R6 backward self branch holds pc", pc_o, 32'h0000_004C);
    // Random programs
    for (int r = 0; r < 6; r++) begin
      build_random();
      load_and_run(160);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule